// File: doc/BRIEF.md
# Banked External Interrupt Router

This block gathers peripheral interrupt lines into banks of 32 and routes each line onto one of several per-thread trigger outputs. Each line has four pieces of state: a status bit, a sense bit that selects edge or level detection, a mask bit, and a small vector register that picks the destination thread. All four can be read and written through a simple 32-bit register port.

Peripheral inputs first pass through a two-flop synchronizer. In edge mode the status bit is set by a synchronized rising edge and stays set. In level mode the status bit follows the synchronized input. Writing a 1 to a status bit inverts it. One write therefore serves as an acknowledge when the bit is set and as a retrigger when it is clear. A level line can be raised again by the same write.

Each trigger output is the registered OR of every line that meets three conditions: its status bit is set, its mask bit is set, and its vector register selects that thread.

Top module: `eirq_router`

## Requirements
- R1: After synchronous reset, all status, sense, mask and vector registers are zero, `trig_out` is zero and `bus_rdata` is zero.
- R2: Hardware line n belongs to bank n/32, bit n%32. Register byte addresses are:
  - status at 0x00+8*b
  - sense at 0x40+8*b
  - mask at 0x80+8*b
  - vector at 0x1000*(b+1)+4*line

  Read data appears on `bus_rdata` the cycle after the request and holds until the next read.
- R3: With sense bit 0 (edge mode), the status bit sets on a rising edge of the synchronized input. The status bit is readable three clock edges after the input rises, and `trig_out` follows one edge later. The bit then stays set regardless of the input until software toggles it.
- R4: Writing a status word inverts every bit written as 1 and leaves every bit written as 0 unchanged. In edge mode, a rising edge in the same cycle as a toggle wins, and the bit ends set.
- R5: With sense bit 1 (level mode), the status bit follows the synchronized input. A toggle write inverts the bit for one cycle only. So writing 1 while the input is high produces a 1-0-1 retrigger on the trigger output.
- R6: A line reaches its trigger output only while its mask bit is 1. Clearing the mask does not alter the status bit.
- R7: A vector value v in 1..NUM_THREADS routes the line to `trig_out[v-1]`. A value of 0, or any value above NUM_THREADS, disconnects the line. `trig_out` reflects the state after the previous clock edge.
- R8: When several lines share one trigger output, that output is the OR of them and spans banks.
- R9: Any access to a bank at or above NUM_BANKS, or to an unmapped address, behaves as follows: reads return zero and writes change no state.
- R10: A vector register keeps only its low clog2(NUM_THREADS+1) bits. Readback returns those bits zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_BANKS*32 | Asynchronous peripheral interrupt lines |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| trig_out | output | NUM_THREADS | Registered per-thread trigger outputs |

## Verification
The embedded properties check the per-bit status rules on every cycle:
- an edge-mode bit that is neither toggled nor re-edged holds its value;
- a toggle flips exactly the written bits unless an edge overrides;
- a level-mode bit tracks the synchronized input.

Further properties check that the trigger outputs stay low while no mask bit is set or no vector register is nonzero, and that reads of absent banks or unmapped addresses return zero.

Only the bench scenarios can show the exact synchronizer latency, the 1-0-1 level retrigger pulse, routing to the selected thread, out-of-range vector values, cross-bank OR merging, and the priority of an edge over a simultaneous toggle.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int BANK_LINES = 32;
    localparam int MAX_BANKS  = 4;
    localparam int LINE_W     = $clog2(BANK_LINES);
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 32;

    typedef enum logic [1:0] {
        GRP_STATUS = 2'd0,
        GRP_SENSE  = 2'd1,
        GRP_MASK   = 2'd2,
        GRP_VECTOR = 2'd3
    } reg_group_e;

    typedef struct packed {
        logic              hit;
        reg_group_e        grp;
        logic [1:0]        bank;
        logic [LINE_W-1:0] line;
    } reg_sel_t;

    // Decode a byte address into register group, bank and line.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t r;
        r = '0;
        if (a[15:12] == 4'd0) begin
            if (a[11:8] == 4'd0 && a[7:6] != 2'b11 && a[5] == 1'b0 &&
                a[2:0] == 3'd0) begin
                r.hit  = 1'b1;
                r.grp  = reg_group_e'(a[7:6]);
                r.bank = a[4:3];
            end
        end else if (a[15:14] == 2'b00 || a[15:12] == 4'd4) begin
            if (a[11:7] == 5'd0 && a[1:0] == 2'd0) begin
                r.hit  = 1'b1;
                r.grp  = GRP_VECTOR;
                r.bank = a[13:12] - 2'd1;
                r.line = a[6:2];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/eirq_sync.sv
// Two-flop synchronizer with rising-edge detect for a vector of lines.
// Assumes inputs are asynchronous and each pulse is held at least two clocks.
module eirq_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] s1_q, s2_q, s3_q;

    // Synchronize and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= async_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign lvl  = s2_q;
    assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/eirq_bank.sv
// One bank of 32 interrupt lines: status, sense, mask and per-line vector.
// Assumes synchronized inputs; write strobes are one-hot per register group.
module eirq_bank
    import eirq_pkg::*;
#(
    parameter int VEC_W = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [BANK_LINES-1:0]                irq_lvl,
    input  logic [BANK_LINES-1:0]                irq_rise,
    input  logic                                 wr_status,
    input  logic                                 wr_sense,
    input  logic                                 wr_mask,
    input  logic                                 wr_vec,
    input  logic [LINE_W-1:0]                    wr_line,
    input  logic [DATA_W-1:0]                    wdata,
    output logic [BANK_LINES-1:0]                status_q,
    output logic [BANK_LINES-1:0]                sense_q,
    output logic [BANK_LINES-1:0]                mask_q,
    output logic [BANK_LINES-1:0][VEC_W-1:0]     vec_q
);
    logic [BANK_LINES-1:0] tog_v, lvl_nxt, edg_nxt, status_nxt;

    // Next status per bit: level lines track input, edge lines latch.
    always_comb begin
        tog_v      = {BANK_LINES{wr_status}} & wdata;
        lvl_nxt    = (tog_v & ~status_q) | (~tog_v & irq_lvl);
        edg_nxt    = irq_rise | (status_q ^ tog_v);
        status_nxt = (sense_q & lvl_nxt) | (~sense_q & edg_nxt);
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_nxt;
    end

    // Sense and mask registers, whole-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            mask_q  <= '0;
        end else begin
            if (wr_sense) sense_q <= wdata;
            if (wr_mask)  mask_q  <= wdata;
        end
    end

    // Per-line vector registers, one written per access.
    always_ff @(posedge clk) begin
        if (!rst_n)      vec_q <= '0;
        else if (wr_vec) vec_q[wr_line] <= wdata[VEC_W-1:0];
    end

    // R3: an untouched edge-mode bit that is set stays set.
    p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(~sense_q & ~tog_v & status_q) & ~status_q) == '0));

    // R4: toggled bits flip unless an edge in edge mode overrides.
    p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(tog_v & ~(~sense_q & irq_rise)) &
                   ~(status_q ^ $past(status_q))) == '0));

    // R5: level-mode bits without a toggle follow the synchronized input.
    p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(sense_q & ~tog_v) & (status_q ^ $past(irq_lvl))) == '0));
endmodule

// File: rtl/eirq_route.sv
// Routes active lines to per-thread triggers by vector value, registered.
// Vector value v in 1..NUM_THREADS selects thread v-1; anything else is off.
module eirq_route #(
    parameter int NUM_LINES   = 128,
    parameter int NUM_THREADS = 4,
    parameter int VEC_W       = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_LINES-1:0]              active,
    input  logic [NUM_LINES-1:0][VEC_W-1:0]   vec,
    output logic [NUM_THREADS-1:0]            trig_q
);
    logic [NUM_THREADS-1:0] hit;

    // OR-reduce every active line whose vector selects each thread.
    always_comb begin
        hit = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            for (int n = 0; n < NUM_LINES; n++) begin
                if (active[n] && vec[n] == VEC_W'(t + 1)) hit[t] = 1'b1;
            end
        end
    end

    // Register the trigger outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= '0;
        else        trig_q <= hit;
    end
endmodule

// File: rtl/eirq_router.sv
// Top of the banked interrupt router: register port, banks and routing.
// Assumes one access per bus_req cycle; read data valid the next cycle.
module eirq_router
    import eirq_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int NUM_THREADS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_BANKS*BANK_LINES-1:0] irq_in,
    input  logic                            bus_req,
    input  logic                            bus_we,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               bus_rdata,
    output logic [NUM_THREADS-1:0]          trig_out
);
    localparam int NUM_LINES = NUM_BANKS * BANK_LINES;
    localparam int VEC_W     = $clog2(NUM_THREADS + 1);

    logic [NUM_LINES-1:0]             irq_lvl, irq_rise, active;
    logic [NUM_LINES-1:0][VEC_W-1:0]  vec_all;
    logic [BANK_LINES-1:0]            st_a  [MAX_BANKS];
    logic [BANK_LINES-1:0]            se_a  [MAX_BANKS];
    logic [BANK_LINES-1:0]            mk_a  [MAX_BANKS];
    logic [BANK_LINES-1:0][VEC_W-1:0] vec_a [MAX_BANKS];
    reg_sel_t                         sel;
    logic                             wr_en;
    logic [DATA_W-1:0]                rd_val;
    logic                             mask_any, vec_any;

    assign sel   = decode_addr(bus_addr);
    assign wr_en = bus_req && bus_we && sel.hit;

    eirq_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .lvl      (irq_lvl),
        .rise     (irq_rise)
    );

    for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
        if (b < NUM_BANKS) begin : g_impl
            logic bank_wr;
            assign bank_wr = wr_en && (sel.bank == 2'(b));
            eirq_bank #(.VEC_W(VEC_W)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .irq_lvl   (irq_lvl[b*BANK_LINES +: BANK_LINES]),
                .irq_rise  (irq_rise[b*BANK_LINES +: BANK_LINES]),
                .wr_status (bank_wr && sel.grp == GRP_STATUS),
                .wr_sense  (bank_wr && sel.grp == GRP_SENSE),
                .wr_mask   (bank_wr && sel.grp == GRP_MASK),
                .wr_vec    (bank_wr && sel.grp == GRP_VECTOR),
                .wr_line   (sel.line),
                .wdata     (bus_wdata),
                .status_q  (st_a[b]),
                .sense_q   (se_a[b]),
                .mask_q    (mk_a[b]),
                .vec_q     (vec_a[b])
            );
            assign active[b*BANK_LINES +: BANK_LINES]  = st_a[b] & mk_a[b];
            assign vec_all[b*BANK_LINES +: BANK_LINES] = vec_a[b];
        end else begin : g_absent
            assign st_a[b]  = '0;
            assign se_a[b]  = '0;
            assign mk_a[b]  = '0;
            assign vec_a[b] = '0;
        end
    end

    eirq_route #(
        .NUM_LINES   (NUM_LINES),
        .NUM_THREADS (NUM_THREADS),
        .VEC_W       (VEC_W)
    ) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .vec    (vec_all),
        .trig_q (trig_out)
    );

    // Select the read word; absent banks are tied to zero.
    always_comb begin
        rd_val = '0;
        if (sel.hit) begin
            case (sel.grp)
                GRP_STATUS: rd_val = st_a[sel.bank];
                GRP_SENSE:  rd_val = se_a[sel.bank];
                GRP_MASK:   rd_val = mk_a[sel.bank];
                default:    rd_val = DATA_W'(vec_a[sel.bank][sel.line]);
            endcase
        end
    end

    // Capture read data on each read request.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_rdata <= '0;
        else if (bus_req && !bus_we) bus_rdata <= rd_val;
    end

    // Summaries used by the checks below.
    always_comb begin
        mask_any = 1'b0;
        for (int b = 0; b < MAX_BANKS; b++) mask_any = mask_any | (|mk_a[b]);
    end
    assign vec_any = |vec_all;

    // R6: with no mask bit set, no trigger can fire next cycle.
    p_mask_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_any |=> (trig_out == '0));

    // R7: with every line disconnected, no trigger can fire next cycle.
    p_unrouted_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_any |=> (trig_out == '0));

    // R9: reads of absent banks or unmapped addresses return zero.
    p_absent_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !(sel.hit && int'(sel.bank) < NUM_BANKS))
        |=> (bus_rdata == '0));
endmodule

// File: tb/eirq_router_bench.sv
module eirq_router_bench;
    localparam int NB = 3;
    localparam int NT = 4;
    localparam int NL = NB * 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   irq_in = '0;
    logic            bus_req = 1'b0;
    logic            bus_we = 1'b0;
    logic [15:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NT-1:0]   trig_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    bit    rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    eirq_router #(.NUM_BANKS(NB), .NUM_THREADS(NT)) u_eirq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .trig_out  (trig_out)
    );

    function automatic logic [15:0] a_st(input int b); return 16'(8*b); endfunction
    function automatic logic [15:0] a_se(input int b); return 16'(32'h40 + 8*b); endfunction
    function automatic logic [15:0] a_mk(input int b); return 16'(32'h80 + 8*b); endfunction
    function automatic logic [15:0] a_vc(input int b, input int l);
        return 16'(32'h1000*(b+1) + 4*l);
    endfunction

    // Monitor: note read requests, compare the next cycle against the queue.
    always @(posedge clk) rd_seen <= bus_req && !bus_we;
    always @(negedge clk) begin
        if (rd_seen) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected read: actual %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    // Driver: push the expected word, then issue the read.
    task automatic bus_read(input logic [15:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic check_trig(input logic [NT-1:0] e, input string t);
        n_cmp++;
        if (trig_out !== e) begin
            n_bad++;
            $display("FAIL %s: trig_out actual %b expected %b", t, trig_out, e);
        end
    endtask

    task automatic check_rdata(input logic [31:0] e, input string t);
        n_cmp++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        check_trig('0, "R1 trig after reset");
        check_rdata('0, "R1 rdata after reset");
        bus_read(a_st(0), 32'h0, "R1 status b0");
        bus_read(a_vc(0, 5), 32'h0, "R1 vector b0 l5");
        bus_read(a_mk(2), 32'h0, "R1 mask b2");
        bus_read(a_se(1), 32'h0, "R1 sense b1");

        // R2: register map and read latency/hold
        bus_write(a_se(1), 32'hA5A5_0001);
        bus_read(a_se(1), 32'hA5A5_0001, "R2 sense b1");
        bus_write(a_mk(2), 32'h8000_0000);
        bus_read(a_mk(2), 32'h8000_0000, "R2 mask b2");
        bus_read(a_mk(0), 32'h0, "R2 mask b0 untouched");
        bus_write(a_vc(2, 7), 32'd3);
        bus_read(a_vc(2, 7), 32'd3, "R2 vector b2 l7");
        // R10: only low VEC_W bits kept
        bus_write(a_vc(2, 7), 32'hFFFF_FFFE);
        bus_read(a_vc(2, 7), 32'd6, "R10 vector width");
        tick(2);
        check_rdata(32'd6, "R2 rdata holds");

        // R3: edge capture on line 33 routed to thread 1
        bus_write(a_mk(1), 32'h2);
        bus_write(a_vc(1, 1), 32'd2);
        irq_in[33] = 1'b1;
        tick(3);
        check_trig(4'b0000, "R3 sync latency");
        tick(1);
        check_trig(4'b0010, "R3 edge trigger");
        bus_read(a_st(1), 32'h2, "R3 status set");
        irq_in[33] = 1'b0;
        tick(4);
        bus_read(a_st(1), 32'h2, "R3 status held");
        check_trig(4'b0010, "R3 trigger held");

        // R4: toggle acknowledge and retrigger
        bus_write(a_st(1), 32'h2);
        bus_read(a_st(1), 32'h0, "R4 ack clears");
        check_trig(4'b0000, "R4 trigger after ack");
        bus_write(a_st(1), 32'h2);
        bus_read(a_st(1), 32'h2, "R4 toggle retriggers");
        bus_write(a_st(1), 32'h0);
        bus_read(a_st(1), 32'h2, "R4 zero write no effect");
        bus_write(a_st(1), 32'h2);
        bus_read(a_st(1), 32'h0, "R4 second ack");

        // R5: level line 32 routed to thread 0
        bus_write(a_mk(1), 32'h3);
        bus_write(a_vc(1, 0), 32'd1);
        irq_in[32] = 1'b1;
        tick(4);
        check_trig(4'b0001, "R5 level trigger");
        bus_read(a_st(1), 32'h1, "R5 status follows high");
        bus_write(a_st(1), 32'h1);
        check_trig(4'b0001, "R5 retrigger before");
        tick(1);
        check_trig(4'b0000, "R5 retrigger dip");
        tick(1);
        check_trig(4'b0001, "R5 retrigger raise");
        irq_in[32] = 1'b0;
        tick(4);
        bus_read(a_st(1), 32'h0, "R5 status follows low");
        check_trig(4'b0000, "R5 trigger low");
        irq_in[32] = 1'b1;
        tick(4);
        check_trig(4'b0001, "R5 level again");

        // R6: mask blocks the trigger, status unchanged
        bus_write(a_mk(1), 32'h2);
        tick(1);
        check_trig(4'b0000, "R6 masked");
        bus_read(a_st(1), 32'h1, "R6 status kept");

        // R7: routing by vector value
        bus_write(a_mk(1), 32'h3);
        tick(1);
        check_trig(4'b0001, "R7 thread 0");
        bus_write(a_vc(1, 0), 32'd0);
        tick(1);
        check_trig(4'b0000, "R7 vector zero");
        bus_write(a_vc(1, 0), 32'd5);
        tick(1);
        check_trig(4'b0000, "R7 vector out of range");
        bus_write(a_vc(1, 0), 32'd4);
        tick(1);
        check_trig(4'b1000, "R7 thread 3");

        // R8: OR across banks on thread 3
        bus_write(a_mk(2), 32'h8000_0001);
        bus_write(a_vc(2, 0), 32'd4);
        irq_in[64] = 1'b1;
        tick(4);
        irq_in[64] = 1'b0;
        irq_in[32] = 1'b0;
        tick(4);
        check_trig(4'b1000, "R8 OR keeps trigger");
        bus_read(a_st(2), 32'h1, "R8 bank2 status");
        bus_write(a_st(2), 32'h1);
        tick(1);
        check_trig(4'b0000, "R8 all cleared");

        // R4: rising edge beats a simultaneous toggle
        bus_write(a_st(2), 32'h2);
        bus_read(a_st(2), 32'h2, "R4 preset line 65");
        irq_in[65] = 1'b1;
        tick(2);
        bus_write(a_st(2), 32'h2);
        bus_read(a_st(2), 32'h2, "R4 edge wins over toggle");
        irq_in[65] = 1'b0;

        // R9: absent bank and unmapped addresses
        bus_read(a_st(3), 32'h0, "R9 absent status");
        bus_write(a_mk(3), 32'hFFFF_FFFF);
        bus_read(a_mk(3), 32'h0, "R9 absent mask");
        bus_write(a_vc(3, 0), 32'd1);
        bus_read(a_vc(3, 0), 32'h0, "R9 absent vector");
        bus_write(16'h000C, 32'hFFFF_FFFF);
        bus_read(16'h000C, 32'h0, "R9 unmapped read");
        bus_read(16'h5000, 32'h0, "R9 beyond vectors");
        bus_read(a_st(1), 32'h0, "R9 unmapped write ignored");
        bus_read(a_mk(0), 32'h0, "R9 mask b0 untouched");
        check_trig(4'b0000, "R9 no trigger");

        tick(3);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 pending reads: actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule